// File: doc/BRIEF.md
# Time-Slot Interchange Switch with Selectable Delay

This block is a time-slot interchange for a parallel word stream. A free-running slot counter, realigned by a frame pulse, divides the stream into `N_CH` timeslots per frame. Every incoming word is stored in one of two data-memory banks. The banks trade roles at each frame boundary. For each outgoing timeslot, a connection-memory entry names the input channel whose word is sent. The same entry also drives an enable for external bus drivers.

A processor-side port loads and reads back the connection memory. A run-time mode input picks one of two read policies. Minimum-delay mode suits voice: a source that arrived earlier in the same frame is sent at once. Constant-delay mode suits grouped data channels: every output word is exactly one frame old. The one exception is that last-channel-to-slot-0 comes out two frames old.

Top module: `tsi_switch`

## Requirements
- R1: Slots advance by one per clock and wrap from `N_CH-1` to 0. A high `fp_i` during a clock makes the following slot 0. Out of reset the first slot is `N_CH-1`.
- R2: The `din_i` word present during slot c of a frame is stored as that frame's channel c. The bank being written swaps at each frame boundary.
- R3: In minimum-delay mode (`mode_i`=0), output slot c with source s<c carries the word input in slot s of the same frame.
- R4: In minimum-delay mode, output slot c with source s>=c carries the word input in slot s of the previous frame.
- R5: In constant-delay mode (`mode_i`=1), every output slot carries its source word from the previous frame, except the case in R6.
- R6: In constant-delay mode, output slot 0 with source `N_CH-1` carries the word from two frames earlier.
- R7: Connection word bits [AW-1:0] name the source channel. Bit `OE_BIT` (13 by default) appears on `oe_o` during the same output slot as the data.
- R8: The word for output slot c is presented on `dout_o` throughout slot c. Entry c and `mode_i` are sampled at the clock that starts slot c.
- R9: A connection-memory write applies from the next read of that entry. A read of the entry at the same clock edge as the write still uses the old value.
- R10: `cm_rdata_o` shows, one clock after `cm_addr_i` is applied, the last value written to that entry.
- R11: While `rst_ni` is low, `dout_o`, `oe_o` and `cm_rdata_o` are 0.
- R12: `mode_i` can change at any slot, and each output slot follows the mode sampled for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse, high during the last slot of a frame |
| din_i | input | DW | Input stream word |
| mode_i | input | 1 | 0 = minimum delay, 1 = constant delay |
| dout_o | output | DW | Switched output word |
| oe_o | output | 1 | External bus-driver enable for the current slot |
| cm_we_i | input | 1 | Connection-memory write strobe |
| cm_addr_i | input | AW | Connection-memory entry (output slot) |
| cm_wdata_i | input | DW | Connection-memory write word |
| cm_rdata_o | output | DW | Connection-memory read word |

## Verification
The hardest situations to reach are the frame-age boundaries: a source exactly one slot before its output, a source equal to its output, and the last channel routed to slot 0 in constant-delay mode. Each of these depends on the exact timing of the bank swap. The bench uses a 16-slot frame so that random mappings hit all of these edges often. A directed stretch also programs the routes 3→5, 6→6, 8→7 and 15→0 and holds them across frames in both modes. Random mid-frame mode flips and writes to the entry being read at that same edge cover the sampling rules.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic {
    MODE_MIN   = 1'b0,
    MODE_CONST = 1'b1
  } dly_mode_e;
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter int N_CH = 1024,
  parameter int AW   = $clog2(N_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fp_i,
  output logic [AW-1:0] slot_o,
  output logic [AW-1:0] next_slot_o,
  output logic          wr_bank_o
);
  localparam logic [AW-1:0] LAST = AW'(N_CH - 1);

  logic [AW-1:0] slot_q;
  logic          bank_q;
  logic          frame_end;

  assign frame_end   = fp_i || (slot_q == LAST);
  assign next_slot_o = frame_end ? '0 : slot_q + 1'b1;
  assign slot_o      = slot_q;
  assign wr_bank_o   = bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= LAST;
      bank_q <= 1'b0;
    end else begin
      slot_q <= next_slot_o;
      if (frame_end) bank_q <= ~bank_q;
    end
  end
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem #(
  parameter int N_CH   = 1024,
  parameter int AW     = $clog2(N_CH),
  parameter int DW     = 16,
  parameter int OE_BIT = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [AW-1:0] raddr_i,
  output logic [AW-1:0] rsrc_o,
  output logic          roe_o
);
  logic [DW-1:0] mem [N_CH];
  logic [DW-1:0] rword;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem[addr_i];
  end

  // switching-side read port, sees writes from the following edge on
  assign rword  = mem[raddr_i];
  assign rsrc_o = rword[AW-1:0];
  assign roe_o  = rword[OE_BIT];
endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem
  import tsi_pkg::*;
#(
  parameter int N_CH = 1024,
  parameter int AW   = $clog2(N_CH),
  parameter int DW   = 16
) (
  input  logic          clk_i,
  input  logic          wr_bank_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] rd_addr_i,
  input  dly_mode_e     rd_mode_i,
  input  logic          rd_wrap_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rd_bank [2];
  logic          src_early, src_same;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] bank_mem [N_CH];
    always_ff @(posedge clk_i) begin
      if (wr_bank_i == 1'(b)) bank_mem[wr_addr_i] <= wdata_i;
    end
    assign rd_bank[b] = bank_mem[rd_addr_i];
  end

  assign src_early = rd_addr_i < wr_addr_i;
  assign src_same  = rd_addr_i == wr_addr_i;

  always_comb begin
    rdata_o = rd_bank[~wr_bank_i];
    if (rd_mode_i == MODE_MIN) begin
      if (src_same)       rdata_o = wdata_i;  // source lands this edge
      else if (src_early) rdata_o = rd_bank[wr_bank_i];
    end else if (rd_wrap_i && src_early) begin
      // slot 0 is fetched in the final slot of the frame before
      rdata_o = rd_bank[wr_bank_i];
    end
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter  int N_CH   = 1024,
  parameter  int DW     = 16,
  parameter  int OE_BIT = 13,
  localparam int AW     = $clog2(N_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fp_i,
  input  logic [DW-1:0] din_i,
  input  logic          mode_i,
  output logic [DW-1:0] dout_o,
  output logic          oe_o,
  input  logic          cm_we_i,
  input  logic [AW-1:0] cm_addr_i,
  input  logic [DW-1:0] cm_wdata_i,
  output logic [DW-1:0] cm_rdata_o
);
  logic [AW-1:0] slot, next_slot, src;
  logic          wr_bank, src_oe;
  logic [DW-1:0] sw_word;

  tsi_timing #(.N_CH(N_CH), .AW(AW)) u_timing (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fp_i        (fp_i),
    .slot_o      (slot),
    .next_slot_o (next_slot),
    .wr_bank_o   (wr_bank)
  );

  tsi_cmem #(.N_CH(N_CH), .AW(AW), .DW(DW), .OE_BIT(OE_BIT)) u_cmem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cm_we_i),
    .addr_i  (cm_addr_i),
    .wdata_i (cm_wdata_i),
    .rdata_o (cm_rdata_o),
    .raddr_i (next_slot),
    .rsrc_o  (src),
    .roe_o   (src_oe)
  );

  tsi_dmem #(.N_CH(N_CH), .AW(AW), .DW(DW)) u_dmem (
    .clk_i     (clk_i),
    .wr_bank_i (wr_bank),
    .wr_addr_i (slot),
    .wdata_i   (din_i),
    .rd_addr_i (src),
    .rd_mode_i (dly_mode_e'(mode_i)),
    .rd_wrap_i (next_slot == '0),
    .rdata_o   (sw_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o <= '0;
      oe_o   <= 1'b0;
    end else begin
      dout_o <= sw_word;
      oe_o   <= src_oe;
    end
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int N_CH = 1024,
  parameter int AW   = $clog2(N_CH),
  parameter int DW   = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fp_i,
  input logic [AW-1:0] slot_i,
  input logic          bank_i,
  input logic          cm_we_i,
  input logic [AW-1:0] cm_addr_i,
  input logic [DW-1:0] cm_wdata_i,
  input logic [DW-1:0] cm_rdata_o,
  input logic [DW-1:0] dout_o,
  input logic          oe_o
);
  localparam logic [AW-1:0] LAST = AW'(N_CH - 1);

  p_slot_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_i || slot_i == LAST) |=> slot_i == '0);

  p_slot_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fp_i && slot_i != LAST) |=> slot_i == $past(slot_i) + 1'b1);

  p_bank_swap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_i || slot_i == LAST) |=> bank_i != $past(bank_i));

  p_bank_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fp_i && slot_i != LAST) |=> $stable(bank_i));

  p_cm_readback_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cm_we_i ##1 (!cm_we_i && cm_addr_i == $past(cm_addr_i)))
      |=> cm_rdata_o == $past(cm_wdata_i, 2));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r11: assert (dout_o == '0 && !oe_o && cm_rdata_o == '0)
        else $error("outputs not cleared in reset");
    end
  end
endmodule

bind tsi_switch tsi_switch_chk #(.N_CH(N_CH), .AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fp_i       (fp_i),
  .slot_i     (slot),
  .bank_i     (wr_bank),
  .cm_we_i    (cm_we_i),
  .cm_addr_i  (cm_addr_i),
  .cm_wdata_i (cm_wdata_i),
  .cm_rdata_o (cm_rdata_o),
  .dout_o     (dout_o),
  .oe_o       (oe_o)
);

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 16;
  localparam int DW   = 16;
  localparam int AW   = $clog2(N);
  localparam int OE   = 13;
  localparam int NFR  = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fp = 1'b0;
  logic [DW-1:0] din = '0;
  logic          mode = 1'b0;
  logic [DW-1:0] dout;
  logic          oe;
  logic          cm_we = 1'b0;
  logic [AW-1:0] cm_addr = '0;
  logic [DW-1:0] cm_wdata = '0;
  logic [DW-1:0] cm_rdata;

  tsi_switch #(.N_CH(N), .DW(DW), .OE_BIT(OE)) u_tsi_switch (
    .clk_i(clk), .rst_ni(rst_n), .fp_i(fp), .din_i(din), .mode_i(mode),
    .dout_o(dout), .oe_o(oe), .cm_we_i(cm_we), .cm_addr_i(cm_addr),
    .cm_wdata_i(cm_wdata), .cm_rdata_o(cm_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [DW-1:0] hist [4][N];
  logic [DW-1:0] cm_m [N];
  bit            cm_known [N];

  // frame whose word feeds output slot c of frame k (R3-R6)
  function automatic int src_frame(int k, int c, int s, bit m);
    if (!m) return (s < c) ? k : k - 1;
    return (c == 0 && s == N - 1) ? k - 2 : k - 1;
  endfunction

  function automatic string mode_tag(int c, int s, bit m);
    if (!m) return (s < c) ? "R3" : "R4";
    return (c == 0 && s == N - 1) ? "R6" : "R5";
  endfunction

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int k, c, nk, nc, s, fr;
    bit exp_v, rd_v, prev_mode;
    logic [DW-1:0] exp_d, exp_rd, w;
    logic exp_oe;
    string tag;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) cm_known[i] = 1'b0;
    exp_v = 0; rd_v = 0; exp_d = '0; exp_oe = 0; exp_rd = '0; tag = "";

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", "dout in reset", dout, '0);
    check("R11", "oe in reset", {15'd0, oe}, '0);
    check("R11", "cm_rdata in reset", cm_rdata, '0);
    rst_n = 1'b1;

    k = 0; c = N - 1;
    while (k < NFR) begin
      if (!(k == 0 && c == N - 1)) @(negedge clk);
      if (exp_v) begin
        check(tag, $sformatf("dout slot %0d frame %0d (R1 R2 R8)", c, k), dout, exp_d);
        check("R7", $sformatf("oe slot %0d frame %0d", c, k), {15'd0, oe}, {15'd0, exp_oe});
      end
      if (rd_v) check("R10", "cm_rdata", cm_rdata, exp_rd);

      prev_mode = mode;
      if (k >= 21 && k <= 23)      mode = 1'b0;
      else if (k >= 24 && k <= 27) mode = 1'b1;
      else if ($urandom % 6 == 0)  mode = 1'($urandom);
      din = DW'($urandom);
      hist[k % 4][c] = din;
      fp = (c == N - 1);

      nc = (c == N - 1) ? 0 : c + 1;
      nk = (c == N - 1) ? k + 1 : k;
      s  = int'(cm_m[nc][AW-1:0]);
      fr = src_frame(nk, nc, s, mode);
      exp_v  = cm_known[nc] && nk >= 3 && fr >= 1;
      exp_d  = hist[fr % 4][s];
      exp_oe = cm_m[nc][OE];
      tag    = mode_tag(nc, s, mode);
      if (mode != prev_mode) tag = {tag, " R12"};

      cm_addr = AW'($urandom);
      cm_we   = 1'b0;
      if (k == 20 && c < 4) begin
        cm_we = 1'b1;
        case (c)
          0: begin cm_addr = 5; w = DW'(3) | DW'(1 << OE); end
          1: begin cm_addr = 6; w = DW'(6); end
          2: begin cm_addr = 7; w = DW'(8) | DW'(1 << OE); end
          default: begin cm_addr = 0; w = DW'(N - 1); end
        endcase
      end else if (k == 30 && c == 4) begin
        cm_we = 1'b1; cm_addr = AW'(nc); w = DW'($urandom);
      end else if ((k < 20 || k > 27) && ($urandom % 4 == 0 || k < 2)) begin
        cm_we = 1'b1;
        w = DW'($urandom);
        if (k < 2) cm_addr = AW'(c);
      end
      rd_v   = cm_known[cm_addr];
      exp_rd = cm_m[cm_addr];
      if (cm_we) begin
        cm_wdata = w;
        if (int'(cm_addr) == nc) tag = {tag, " R9"};  // same-edge read keeps old entry
        cm_m[cm_addr] = w;
        cm_known[cm_addr] = 1'b1;
      end
      k = nk; c = nc;
    end
    @(negedge clk);
    cm_we = 1'b0;
    finish_run();
  end
endmodule